// File: doc/BRIEF.md
# CCD Horizontal Line Timer

This block generates the horizontal readout timing for one line of a frame-transfer CCD image sensor. It runs from a master clock six times faster than the pixel rate, so every pixel period is split into six ticks. Each line starts with a stop window. In that window the horizontal register clocks are frozen, the vertical sequencer is asked to shift one line down from the storage section, and a black-level clamp strobe can be placed. A readout window follows. In it, three overlapping register clocks, a reset-gate pulse and a summing-gate pulse move the pixels out, and every pixel is tagged with its region.

The vertical sequencer is outside this block. It receives a one-cycle request at the start of each stop window and answers with a done pulse. Readout starts at the first pixel boundary that satisfies two conditions: the minimum stop length has elapsed, and the done pulse has arrived. If the answer is late, the stop window grows in whole pixel periods. With the default parameters and a prompt answer, a line is 105 stopped periods plus 1079 readout periods, 1184 periods in all.

Top module: `ccd_line_timer`

## Requirements
- R1: While `rst` is high, every output is low.
- R2: `line_shift_req` is high for exactly one master cycle at the first tick of each stop window, and at no other time.
- R3: During the stop window, `hclk_run` is low and `reg_c1`, `reg_c2`, `reg_c3`, `reset_gate`, `sum_gate` and `pix_region` are all low. The window lasts at least `N_STOP` pixel periods of six master cycles each.
- R4: Readout begins on the first pixel boundary at which two things are true: `N_STOP` periods have elapsed, and a `line_shift_done` pulse has been seen since the request. A done pulse on the last tick before a boundary still counts for that boundary. A later pulse stretches the window by whole pixel periods.
- R5: A `line_shift_done` pulse that arrives during readout has no effect on the next line.
- R6: Readout lasts `N_DUMMY + 2*N_BLACK + 2*N_TIMING + N_ACTIVE` pixel periods, with `hclk_run` high. The next stop window (and its request) follows immediately after it.
- R7: During readout, with ticks 0 to 5 in a pixel period, `reg_c1` is high on ticks 0 to 2, `reg_c2` on ticks 2 to 4, and `reg_c3` on ticks 4, 5 and 0.
- R8: During readout, `reset_gate` is high on tick 0 only and `sum_gate` is high on ticks 3 to 5.
- R9: During readout, `pix_region` reports 0 for dummy, 1 for black, 2 for timing and 3 for active pixels. The order is `N_DUMMY` dummy, `N_BLACK` black, `N_TIMING` timing, `N_ACTIVE` active, `N_TIMING` timing, then `N_BLACK` black.
- R10: `clamp` is high for `CLAMP_LEN` pixel periods, starting `CLAMP_START` periods after the line starts. This span must lie inside the stop window (`CLAMP_START + CLAMP_LEN <= N_STOP - 1`).
- R11: One cycle after `enable` is sampled low, every output is low and stays low. Two cycles after `enable` is sampled high again (or after `rst` is released with `enable` high), a fresh line starts with its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, six ticks per pixel |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run line timing when high |
| line_shift_done | input | 1 | Vertical sequencer finished the line shift |
| line_shift_req | output | 1 | One-cycle request for a storage line shift |
| hclk_run | output | 1 | High during readout, low in the stop window |
| reg_c1 | output | 1 | Horizontal register clock phase 1 |
| reg_c2 | output | 1 | Horizontal register clock phase 2 |
| reg_c3 | output | 1 | Horizontal register clock phase 3 |
| reset_gate | output | 1 | Reset-gate pulse, once per pixel |
| sum_gate | output | 1 | Summing-gate pulse |
| clamp | output | 1 | Black-level clamp strobe |
| pix_region | output | 2 | Region tag of the current readout pixel |

## Verification
The assertions place no restriction on `line_shift_done`; they hold for any pattern of done pulses, including pulses that arrive during readout. They only assume that `rst` starts high, so that properties are disabled before the first line. The stimulus sends single-cycle done pulses at chosen offsets from each request: early, on the last tick before a boundary, one tick after it, well after the minimum window, and in mid-readout. Each offset yields a precise expected readout start. `enable` is changed only on falling clock edges, so every transition is sampled cleanly.

// File: rtl/ccd_lt_pkg.sv
package ccd_lt_pkg;
  localparam int TICKS_PER_PIX = 6;
  localparam int TICK_W        = 3;

  typedef enum logic [1:0] {
    RG_DUMMY  = 2'd0,
    RG_BLACK  = 2'd1,
    RG_TIMING = 2'd2,
    RG_ACTIVE = 2'd3
  } region_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_STOP = 2'd1,
    SQ_READ = 2'd2
  } seq_state_t;
endpackage

// File: rtl/ccd_lt_sequencer.sv
module ccd_lt_sequencer
  import ccd_lt_pkg::*;
#(
  parameter int N_STOP   = 105,
  parameter int READ_PIX = 1079,
  parameter int PIX_W    = 11
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      enable,
  input  logic                      shift_done,
  output seq_state_t                state,
  output logic [TICK_W-1:0]         tick,
  output logic [PIX_W-1:0]          pix
);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS_PER_PIX - 1);
  localparam logic [PIX_W-1:0]  STOP_LAST = PIX_W'(N_STOP - 1);
  localparam logic [PIX_W-1:0]  READ_LAST = PIX_W'(READ_PIX - 1);

  logic seen;
  logic tick_end;

  assign tick_end = (tick == TICK_LAST);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state <= SQ_IDLE;
      tick  <= '0;
      pix   <= '0;
      seen  <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: begin
          state <= SQ_STOP;
          tick  <= '0;
          pix   <= '0;
          seen  <= 1'b0;
        end
        SQ_STOP: begin
          seen <= seen | shift_done;
          if (tick_end) begin
            tick <= '0;
            if (pix == STOP_LAST) begin
              if (seen || shift_done) begin
                state <= SQ_READ;
                pix   <= '0;
                seen  <= 1'b0;
              end
            end else begin
              pix <= pix + 1'b1;
            end
          end else begin
            tick <= tick + 1'b1;
          end
        end
        SQ_READ: begin
          if (tick_end) begin
            tick <= '0;
            if (pix == READ_LAST) begin
              state <= SQ_STOP;
              pix   <= '0;
            end else begin
              pix <= pix + 1'b1;
            end
          end else begin
            tick <= tick + 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ccd_lt_phase.sv
module ccd_lt_phase
  import ccd_lt_pkg::*;
(
  input  logic [TICK_W-1:0] tick,
  output logic [2:0]        creg,
  output logic              rg,
  output logic              sg
);
  localparam int HALF = TICKS_PER_PIX / 2;
  localparam int STEP = TICKS_PER_PIX / 3;

  for (genvar i = 0; i < 3; i++) begin : g_phase
    logic [TICK_W:0] off;
    always_comb begin
      off = {1'b0, tick} + (TICK_W+1)'(TICKS_PER_PIX - STEP * i);
      if (off >= (TICK_W+1)'(TICKS_PER_PIX)) off = off - (TICK_W+1)'(TICKS_PER_PIX);
      creg[i] = (off < (TICK_W+1)'(HALF));
    end
  end

  assign rg = (tick == '0);
  assign sg = (tick >= TICK_W'(HALF));
endmodule

// File: rtl/ccd_lt_region.sv
module ccd_lt_region
  import ccd_lt_pkg::*;
#(
  parameter int N_DUMMY  = 7,
  parameter int N_BLACK  = 20,
  parameter int N_TIMING = 4,
  parameter int N_ACTIVE = 1024,
  parameter int PIX_W    = 11
) (
  input  logic [PIX_W-1:0] pix,
  output region_t          region
);
  localparam int END_DUMMY = N_DUMMY;
  localparam int END_BLK1  = END_DUMMY + N_BLACK;
  localparam int END_TIM1  = END_BLK1 + N_TIMING;
  localparam int END_ACT   = END_TIM1 + N_ACTIVE;
  localparam int END_TIM2  = END_ACT + N_TIMING;

  always_comb begin
    if (pix < PIX_W'(END_DUMMY))     region = RG_DUMMY;
    else if (pix < PIX_W'(END_BLK1)) region = RG_BLACK;
    else if (pix < PIX_W'(END_TIM1)) region = RG_TIMING;
    else if (pix < PIX_W'(END_ACT))  region = RG_ACTIVE;
    else if (pix < PIX_W'(END_TIM2)) region = RG_TIMING;
    else                             region = RG_BLACK;
  end
endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
  import ccd_lt_pkg::*;
#(
  parameter int N_DUMMY     = 7,
  parameter int N_BLACK     = 20,
  parameter int N_TIMING    = 4,
  parameter int N_ACTIVE    = 1024,
  parameter int N_STOP      = 105,
  parameter int CLAMP_START = 30,
  parameter int CLAMP_LEN   = 30
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       line_shift_done,
  output logic       line_shift_req,
  output logic       hclk_run,
  output logic       reg_c1,
  output logic       reg_c2,
  output logic       reg_c3,
  output logic       reset_gate,
  output logic       sum_gate,
  output logic       clamp,
  output logic [1:0] pix_region
);
  localparam int READ_PIX = N_DUMMY + 2 * N_BLACK + 2 * N_TIMING + N_ACTIVE;
  localparam int MAX_PIX  = (READ_PIX > N_STOP) ? READ_PIX : N_STOP;
  localparam int PIX_W    = $clog2(MAX_PIX + 1);
  localparam logic [PIX_W-1:0] CL_LO = PIX_W'(CLAMP_START);
  localparam logic [PIX_W-1:0] CL_HI = PIX_W'(CLAMP_START + CLAMP_LEN);

  seq_state_t         state;
  logic [TICK_W-1:0]  tick;
  logic [PIX_W-1:0]   pix;
  logic [2:0]         creg;
  logic               rg_w, sg_w;
  region_t            region;

  ccd_lt_sequencer #(
    .N_STOP  (N_STOP),
    .READ_PIX(READ_PIX),
    .PIX_W   (PIX_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .shift_done(line_shift_done),
    .state     (state),
    .tick      (tick),
    .pix       (pix)
  );

  ccd_lt_phase u_phase (
    .tick(tick),
    .creg(creg),
    .rg  (rg_w),
    .sg  (sg_w)
  );

  ccd_lt_region #(
    .N_DUMMY (N_DUMMY),
    .N_BLACK (N_BLACK),
    .N_TIMING(N_TIMING),
    .N_ACTIVE(N_ACTIVE),
    .PIX_W   (PIX_W)
  ) u_region (
    .pix   (pix),
    .region(region)
  );

  logic in_read, in_stop;
  assign in_read = (state == SQ_READ);
  assign in_stop = (state == SQ_STOP);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      line_shift_req <= 1'b0;
      hclk_run       <= 1'b0;
      reg_c1         <= 1'b0;
      reg_c2         <= 1'b0;
      reg_c3         <= 1'b0;
      reset_gate     <= 1'b0;
      sum_gate       <= 1'b0;
      clamp          <= 1'b0;
      pix_region     <= 2'd0;
    end else begin
      line_shift_req <= in_stop && (pix == '0) && (tick == '0);
      hclk_run       <= in_read;
      reg_c1         <= in_read && creg[0];
      reg_c2         <= in_read && creg[1];
      reg_c3         <= in_read && creg[2];
      reset_gate     <= in_read && rg_w;
      sum_gate       <= in_read && sg_w;
      clamp          <= in_stop && (pix >= CL_LO) && (pix < CL_HI);
      pix_region     <= in_read ? region : RG_DUMMY;
    end
  end
endmodule

// File: rtl/ccd_line_timer_chk.sv
module ccd_line_timer_chk (
  input logic       clk,
  input logic       rst,
  input logic       enable,
  input logic       line_shift_done,
  input logic       line_shift_req,
  input logic       hclk_run,
  input logic       reg_c1,
  input logic       reg_c2,
  input logic       reg_c3,
  input logic       reset_gate,
  input logic       sum_gate,
  input logic       clamp,
  input logic [1:0] pix_region
);
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    line_shift_req |=> !line_shift_req); // R2

  AST_REQ_IN_STOP: assert property (@(posedge clk) disable iff (rst)
    line_shift_req |-> !hclk_run); // R2

  AST_CLOCKS_HELD: assert property (@(posedge clk) disable iff (rst)
    !hclk_run |-> !(reg_c1 || reg_c2 || reg_c3 || reset_gate || sum_gate)); // R3

  AST_PHASE_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    hclk_run |-> ($countones({reg_c1, reg_c2, reg_c3}) >= 1 &&
                  $countones({reg_c1, reg_c2, reg_c3}) <= 2)); // R7

  AST_RG_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    reset_gate |-> (reg_c1 && reg_c3 && !reg_c2)); // R8

  AST_SG_LATE_HALF: assert property (@(posedge clk) disable iff (rst)
    sum_gate |-> !reg_c1); // R8

  AST_REGION_IDLE: assert property (@(posedge clk) disable iff (rst)
    !hclk_run |-> (pix_region == 2'd0)); // R9

  AST_CLAMP_IN_STOP: assert property (@(posedge clk) disable iff (rst)
    clamp |-> !hclk_run); // R10

  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !(line_shift_req || hclk_run || clamp || reset_gate)); // R11
endmodule

bind ccd_line_timer ccd_line_timer_chk u_chk (.*);

// File: tb/ccd_line_timer_test.sv
module ccd_line_timer_test;
  localparam int ND = 2, NB = 3, NT = 2, NA = 8;
  localparam int NS = 10, CS = 2, CL = 4;
  localparam int RD = ND + 2 * NB + 2 * NT + NA;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b1;
  logic done = 1'b0;
  logic req, run, c1, c2, c3, rg, sg, clmp;
  logic [1:0] reg_o;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  ccd_line_timer #(
    .N_DUMMY(ND), .N_BLACK(NB), .N_TIMING(NT), .N_ACTIVE(NA),
    .N_STOP(NS), .CLAMP_START(CS), .CLAMP_LEN(CL)
  ) uut (
    .clk(clk), .rst(rst), .enable(enable), .line_shift_done(done),
    .line_shift_req(req), .hclk_run(run), .reg_c1(c1), .reg_c2(c2),
    .reg_c3(c3), .reset_gate(rg), .sum_gate(sg), .clamp(clmp),
    .pix_region(reg_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int region_of(input int p);
    if (p < ND) return 0;
    if (p < ND + NB) return 1;
    if (p < ND + NB + NT) return 2;
    if (p < ND + NB + NT + NA) return 3;
    if (p < ND + NB + 2 * NT + NA) return 2;
    return 1;
  endfunction

  // At the negedge of the request cycle; dly = cycle offset of done pulse,
  // xdly = offset of an extra done pulse (negative for none).
  task automatic run_line(input int dly, input int xdly);
    int j, m, last;
    j = dly + 1;
    m = NS;
    while (6 * m - 1 < j) m++;
    last = 6 * m + 6 * RD - 1;
    for (int k = 0; k <= last; k++) begin
      if (k > 0) @(negedge clk);
      done = (k == dly) || (k == xdly);
      if (k < 6 * m) begin
        chk("R2 req", req, (k == 0));
        chk("R3 stop", {run, c1, c2, c3, rg, sg, reg_o}, 0);
        chk("R10 clamp", clmp, ((k / 6) >= CS && (k / 6) < CS + CL));
        if (k == 6 * m - 1) chk("R4 start", run, 0);
      end else begin
        int r, p, t;
        r = k - 6 * m;
        p = r / 6;
        t = r % 6;
        if (r == 0) chk("R4 start", run, 1);
        chk("R6 run", {req, run, clmp}, 3'b010);
        chk("R7 phases", {c1, c2, c3}, {(t <= 2), (t >= 2 && t <= 4), (t >= 4 || t == 0)});
        chk("R8 gates", {rg, sg}, {(t == 0), (t >= 3)});
        chk("R9 region", reg_o, region_of(p));
      end
    end
    @(negedge clk);
    done = 1'b0;
    chk("R6 next line req", req, 1);
  endtask

  task automatic wait_req(input int gap, input string tag);
    for (int i = 1; i <= gap; i++) begin
      @(negedge clk);
      chk(tag, req, (i == gap));
    end
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1 reset", {req, run, c1, c2, c3, rg, sg, clmp, reg_o}, 0);
    end
    rst = 1'b0;
    wait_req(2, "R11 start after reset");
    run_line(3, -1);              // early done
    run_line(6 * NS + 8, -1);     // late done, stretched window
    run_line(6 * NS - 2, -1);     // done on last tick before boundary
    run_line(6 * NS - 1, -1);     // one tick later: one extra pixel
    run_line(2, 6 * NS + 20);     // R5 pulse during readout
    run_line(6 * NS + 3, -1);     // R5: next line must still wait
    // abort mid-readout
    for (int k = 1; k <= 6 * NS + 20; k++) begin
      @(negedge clk);
      done = (k == 3);
    end
    enable = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk("R11 disabled", {req, run, c1, c2, c3, rg, sg, clmp, reg_o}, 0);
    end
    enable = 1'b1;
    wait_req(2, "R11 re-enable req");
    run_line(5, -1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule